// File: doc/BRIEF.md
# Decoded RAM and ROM Memory Subsystem

This block is a small byte-wide memory subsystem that sits on a processor-style address bus. It holds four 128-byte RAM banks and one 512-byte ROM inside a 10-bit address space. A fixed address decoder turns the upper address bits into a pair of chip selects for every bank: one select active high and one active low. The lower address bits pick the byte inside whichever bank is selected.

A host drives an address, a read strobe, a write strobe and write data. RAM writes take effect on the rising clock edge. Reads are combinational and appear in the same cycle. A tri-state data bus is modelled here as a drive-enable flag (`bus_drive`) plus a muxed read bus (`bus_rdata`). The read bus carries 0x00 whenever no device drives it. The ROM contents are a fixed function of the ROM address, so no file is needed to load them. Reset leaves the RAM contents as they are.

Top module: `memsys_top`

## Requirements
- R1: RAM bank k (k = 0..3) answers at addresses 0x080*k to 0x080*k+0x07F, and address bits 6:0 pick one of its 128 bytes. A read returns the last byte written to that exact address.
- R2: A bank accepts an access only when its active-high select is 1 and its active-low select is 0. The active-high select of RAM k is the decode of address bits 8:7 equal to k, and the active-low select of every RAM is address bit 9. Bytes at the same offset in different banks are therefore independent.
- R3: When the read strobe is high, the selected device drives its stored byte, and no RAM location changes even if the write strobe is also high.
- R4: With the read strobe low and the write strobe high, the addressed RAM byte takes the write data at the next rising clock edge. During that cycle `bus_drive` is 0 and `bus_rdata` is 0x00.
- R5: With both strobes low, nothing is stored, `bus_drive` is 0 and `bus_rdata` is 0x00.
- R6: Addresses 0x200 to 0x3FF select the ROM, which uses address bits 8:0. A read there returns (addr[7:0] XOR 0xA5) XOR (0x5A if addr[8] is 1, else 0x00).
- R7: A write to the ROM range changes neither the ROM data nor any RAM byte.
- R8: At most one device drives the bus in a cycle, and `bus_rdata` is 0x00 whenever `bus_drive` is 0.
- R9: The whole 10-bit space is mapped, so `bus_drive` equals the read strobe. Read data is valid in the same cycle in which the address and strobe are presented.
- R10: Reset (`rst_n` low) does not clear the RAM. Writes presented while reset is asserted are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; RAM writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| bus_addr | input | 10 | Byte address |
| bus_rd | input | 1 | Read strobe; takes priority over write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0x00 when undriven |
| bus_drive | output | 1 | High when a device drives `bus_rdata` |

## Verification
A fault in the decoder or in a bank's select gate shows up as aliasing. A byte written at one offset then reads back from a sibling bank, or from the ROM range, at the very next read. For that reason the bench places different data at the same offset in all four banks before reading any of them. A wrong write-enable or read-priority decision corrupts a stored byte. That damage stays hidden until the location is read again, so every write-blocking scenario is followed at once by a read-back. ROM and bus-drive faults appear combinationally, in the same cycle as the access.

// File: rtl/memsys_pkg.sv
package memsys_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int RAM_AW = 7;
    localparam int ROM_AW = 9;
    localparam int N_RAM  = 4;
    localparam logic [DATA_W-1:0] ROM_MASK_LO = 8'hA5;
    localparam logic [DATA_W-1:0] ROM_MASK_HI = 8'h5A;

    typedef struct packed {
        logic act_hi;
        logic act_lo_n;
    } chip_sel_t;
endpackage

// File: rtl/mem_addr_decode.sv
module mem_addr_decode
    import memsys_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int BANK_AW = RAM_AW,
    parameter int NBANK  = N_RAM
) (
    input  logic [AW-1:0] addr,
    output chip_sel_t     ram_sel [NBANK],
    output chip_sel_t     rom_sel
);
    localparam int SEL_W = AW - 1 - BANK_AW;

    logic [SEL_W-1:0] bank_idx;
    logic             region_bit;

    always_comb begin
        bank_idx   = addr[AW-2:BANK_AW];
        region_bit = addr[AW-1];
    end

    for (genvar k = 0; k < NBANK; k++) begin : g_dec
        always_comb begin
            ram_sel[k].act_hi   = (bank_idx == SEL_W'(k));
            ram_sel[k].act_lo_n = region_bit;
        end
    end

    always_comb begin
        rom_sel.act_hi   = region_bit;
        rom_sel.act_lo_n = 1'b0;
    end
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          drive
);
    localparam int DEPTH = 1 << AW;

    typedef logic [DEPTH-1:0][DW-1:0] store_t;

    store_t store_d, store_q;
    logic   picked;
    logic   commit;

    always_comb begin
        picked  = cs_hi && !cs_lo_n;
        drive   = picked && rd;
        commit  = picked && !rd && wr && rst_n;
        rdata   = drive ? store_q[addr] : '0;
        store_d = store_q;
        if (commit) store_d[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    // R4: a plain write lands at the addressed byte
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && !cs_lo_n && !rd && wr) |=> store_q[$past(addr)] == $past(wdata));

    // R2, R3, R5: no change unless selected with write-only strobes
    assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd || !wr || !cs_hi || cs_lo_n) |=> store_q == $past(store_q));
endmodule

// File: rtl/rom_bank.sv
module rom_bank
    import memsys_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int DW = DATA_W
) (
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata,
    output logic          drive
);
    function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = a[DW-1:0] ^ ROM_MASK_LO;
        if (a[AW-1]) v = v ^ ROM_MASK_HI;
        return v;
    endfunction

    always_comb begin
        drive = cs_hi && !cs_lo_n && rd;
        rdata = drive ? rom_word(addr) : '0;
    end
endmodule

// File: rtl/memsys_top.sv
module memsys_top
    import memsys_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int RAW   = RAM_AW,
    parameter int OAW   = ROM_AW,
    parameter int NBANK = N_RAM
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_drive
);
    chip_sel_t         ram_sel [NBANK];
    chip_sel_t         rom_sel;
    logic [DW-1:0]     ram_rd  [NBANK];
    logic [NBANK-1:0]  ram_drv;
    logic [DW-1:0]     rom_rd;
    logic              rom_drv;

    mem_addr_decode #(.AW(AW), .BANK_AW(RAW), .NBANK(NBANK)) u_dec (
        .addr    (bus_addr),
        .ram_sel (ram_sel),
        .rom_sel (rom_sel)
    );

    for (genvar k = 0; k < NBANK; k++) begin : g_ram
        ram_bank #(.AW(RAW), .DW(DW)) u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .cs_hi   (ram_sel[k].act_hi),
            .cs_lo_n (ram_sel[k].act_lo_n),
            .rd      (bus_rd),
            .wr      (bus_wr),
            .addr    (bus_addr[RAW-1:0]),
            .wdata   (bus_wdata),
            .rdata   (ram_rd[k]),
            .drive   (ram_drv[k])
        );
    end

    rom_bank #(.AW(OAW), .DW(DW)) u_rom (
        .cs_hi   (rom_sel.act_hi),
        .cs_lo_n (rom_sel.act_lo_n),
        .rd      (bus_rd),
        .addr    (bus_addr[OAW-1:0]),
        .rdata   (rom_rd),
        .drive   (rom_drv)
    );

    always_comb begin
        bus_rdata = rom_rd;
        for (int k = 0; k < NBANK; k++) bus_rdata = bus_rdata | ram_rd[k];
        bus_drive = rom_drv || (|ram_drv);
    end

    assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_drv, rom_drv}));

    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> bus_rdata == '0);

    assert_rom_masks_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[AW-1] |-> ram_drv == '0);

    assert_drive_tracks_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive == bus_rd);
endmodule

// File: tb/tb_memsys_top.sv
module tb_memsys_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_drive;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    memsys_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_drive (bus_drive)
    );

    function automatic logic [7:0] rom_exp(input logic [9:0] a);
        return a[7:0] ^ 8'hA5 ^ (a[8] ? 8'h5A : 8'h00);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic put(input logic [9:0] a, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        #1;
    endtask

    task automatic wr_byte(input string req, input logic [9:0] a, input logic [7:0] d);
        put(a, 1'b0, 1'b1, d);
        check({req, " write drive"}, {7'd0, bus_drive}, 8'd0);
        check({req, " write rdata"}, bus_rdata, 8'h00);
    endtask

    task automatic rd_byte(input string req, input logic [9:0] a, input logic [7:0] exp);
        put(a, 1'b1, 1'b0, 8'h00);
        check({req, " read drive"}, {7'd0, bus_drive}, 8'd1);
        check({req, " read data"}, bus_rdata, exp);
    endtask

    task automatic t_reset_state;
        put(10'h000, 1'b0, 1'b0, 8'h00);
        check("R5 reset drive", {7'd0, bus_drive}, 8'd0);
        check("R5 reset rdata", bus_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_ram_walk;
        logic [9:0] offs [3] = '{10'h000, 10'h001, 10'h07F};
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 3; j++)
                wr_byte("R4", 10'(k * 128) + offs[j], 8'(k * 37 + j * 11 + 1));
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 3; j++)
                rd_byte("R1", 10'(k * 128) + offs[j], 8'(k * 37 + j * 11 + 1));
    endtask

    task automatic t_alias;
        wr_byte("R2", 10'h005, 8'h11);
        wr_byte("R2", 10'h085, 8'h22);
        wr_byte("R2", 10'h105, 8'h33);
        wr_byte("R2", 10'h185, 8'h44);
        rd_byte("R2 bank0", 10'h005, 8'h11);
        rd_byte("R2 bank1", 10'h085, 8'h22);
        rd_byte("R2 bank2", 10'h105, 8'h33);
        rd_byte("R2 bank3", 10'h185, 8'h44);
    endtask

    task automatic t_read_priority;
        wr_byte("R3", 10'h0C0, 8'h5C);
        put(10'h0C0, 1'b1, 1'b1, 8'hE7);
        check("R3 both strobes drive", {7'd0, bus_drive}, 8'd1);
        check("R3 both strobes data", bus_rdata, 8'h5C);
        rd_byte("R3 after", 10'h0C0, 8'h5C);
    endtask

    task automatic t_idle;
        wr_byte("R5", 10'h140, 8'h6E);
        put(10'h140, 1'b0, 1'b0, 8'h01);
        check("R5 idle drive", {7'd0, bus_drive}, 8'd0);
        check("R5 idle rdata", bus_rdata, 8'h00);
        put(10'h240, 1'b0, 1'b0, 8'h01);
        check("R5 idle rom rdata", bus_rdata, 8'h00);
        rd_byte("R5 after", 10'h140, 8'h6E);
    endtask

    task automatic t_rom;
        logic [9:0] pts [6] = '{10'h200, 10'h201, 10'h2FF, 10'h300, 10'h35A, 10'h3FF};
        for (int j = 0; j < 6; j++) rd_byte("R6", pts[j], rom_exp(pts[j]));
    endtask

    task automatic t_rom_write;
        wr_byte("R7", 10'h005, 8'h11);
        wr_byte("R7", 10'h205, 8'h99);
        wr_byte("R7", 10'h385, 8'h77);
        rd_byte("R7 rom", 10'h205, rom_exp(10'h205));
        rd_byte("R7 rom hi", 10'h385, rom_exp(10'h385));
        rd_byte("R7 ram0", 10'h005, 8'h11);
        rd_byte("R7 ram3", 10'h185, 8'h44);
    endtask

    task automatic t_same_cycle;
        wr_byte("R9", 10'h1AA, 8'h3C);
        put(10'h1AA, 1'b1, 1'b0, 8'h00);
        check("R9 same-cycle data", bus_rdata, 8'h3C);
        bus_addr = 10'h2AA;
        #1;
        check("R9 addr change data", bus_rdata, rom_exp(10'h2AA));
        check("R8 drive on rom", {7'd0, bus_drive}, 8'd1);
        bus_rd = 1'b0;
        #1;
        check("R8 undriven rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_reset_keep;
        wr_byte("R10", 10'h07F, 8'hC3);
        @(negedge clk); rst_n = 1'b0;
        put(10'h07F, 1'b0, 1'b1, 8'h00);
        put(10'h07F, 1'b0, 1'b1, 8'h00);
        put(10'h000, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        rd_byte("R10 kept", 10'h07F, 8'hC3);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_ram_walk();
        t_alias();
        t_read_priority();
        t_idle();
        t_rom();
        t_rom_write();
        t_same_cycle();
        t_reset_keep();
        put(10'h000, 1'b0, 1'b0, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule